// File: doc/BRIEF.md
# Scaled-Index Effective Address Calculator

This block forms the effective address of a memory operand that may combine a base register, an index register multiplied by a power of two, and a signed displacement. A decoder upstream supplies an addressing form code, the two register numbers, a two-bit scale code, the displacement and a flag that tells whether the displacement was a one-byte or a four-byte field. The contents of all eight general registers are presented in parallel on one flattened bus. Register k occupies bits [32k+31:32k].

Each accepted request produces a 32-bit address and an illegal-operand flag one clock later, through a single output register stage. Some combinations are not encodable. These are the stack pointer used as index, a short displacement in the index-only form, and the two unused form codes. For these the block raises the flag, and the address value has no meaning. Instruction byte decoding and segment arithmetic happen elsewhere.

Top module: `scaled_ea_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `ea` and `illegal` are all 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so every result appears exactly one cycle after its request.
- R3: `scale_code` 0, 1, 2 and 3 multiply the index register by 1, 2, 4 and 8 respectively.
- R4: When `disp_is_long` is 0, only `disp[7:0]` is used, sign-extended from bit 7; when it is 1, all 32 bits of `disp` are used.
- R5: Form 0 (direct) gives `ea = disp[31:0]` and is never illegal; `disp_is_long` has no effect on it.
- R6: Form 1 (register indirect) gives `ea` = the base register.
- R7: Form 2 gives `ea` = base register + displacement.
- R8: Form 3 gives `ea` = index register × scale + displacement; with `disp_is_long` = 0 it is illegal.
- R9: Form 4 gives `ea` = base register + index register × scale; the displacement has no effect.
- R10: Form 5 gives `ea` = base register + index register × scale + displacement.
- R11: In forms 3, 4 and 5 an `index_sel` of 4 (the stack pointer) sets `illegal`; register 4 remains legal as a base.
- R12: Form codes 6 and 7 set `illegal`.
- R13: All address sums wrap modulo 2^32.
- R14: In a cycle with `in_valid` low, `ea` and `illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing form code 0..7 |
| regs | input | 256 | Eight general registers, register k at bits [32k+31:32k] |
| base_sel | input | 3 | Base register number |
| index_sel | input | 3 | Index register number |
| scale_code | input | 2 | Index scale, shift of 0..3 |
| disp | input | 32 | Displacement, or absolute address in form 0 |
| disp_is_long | input | 1 | 1: 32-bit displacement, 0: 8-bit in disp[7:0] |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| illegal | output | 1 | Operand combination not allowed |

## Verification
The assertions assume that every request input holds a known value in any cycle where `in_valid` is high. They also assume that `rst_n` is released away from a clock edge. The stimulus changes inputs only on falling edges and never drives X or Z. The bench sweeps every form code, both register selects, every scale and both displacement sizes against several displacement values. The register values are chosen so that the sums overflow 32 bits. It also holds `in_valid` low while the other inputs change, to confirm that the outputs do not move.

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit #(
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int SHORT_W = 8,
  parameter int SP_SEL  = 4,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [2:0]             mode,
  input  logic [NREG*DATA_W-1:0] regs,
  input  logic [SEL_W-1:0]       base_sel,
  input  logic [SEL_W-1:0]       index_sel,
  input  logic [1:0]             scale_code,
  input  logic [DATA_W-1:0]      disp,
  input  logic                   disp_is_long,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      ea,
  output logic                   illegal
);

  localparam logic [2:0] F_DIRECT = 3'd0;
  localparam logic [2:0] F_IND    = 3'd1;
  localparam logic [2:0] F_BD     = 3'd2;
  localparam logic [2:0] F_ISD    = 3'd3;
  localparam logic [2:0] F_BI     = 3'd4;
  localparam logic [2:0] F_BID    = 3'd5;

  logic [DATA_W-1:0] base_val, index_val, scaled, disp_ext, sum_d;
  logic              bad_d, sp_index;

  assign base_val  = regs[base_sel*DATA_W +: DATA_W];
  assign index_val = regs[index_sel*DATA_W +: DATA_W];
  assign scaled    = index_val << scale_code;
  assign disp_ext  = disp_is_long ? disp
                   : {{(DATA_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign sp_index  = (index_sel == SEL_W'(SP_SEL));

  always_comb begin
    sum_d = '0;
    bad_d = 1'b0;
    case (mode)
      F_DIRECT: sum_d = disp;
      F_IND:    sum_d = base_val;
      F_BD:     sum_d = base_val + disp_ext;
      F_ISD: begin
        sum_d = scaled + disp_ext;
        bad_d = sp_index | ~disp_is_long;
      end
      F_BI: begin
        sum_d = base_val + scaled;
        bad_d = sp_index;
      end
      F_BID: begin
        sum_d = base_val + scaled + disp_ext;
        bad_d = sp_index;
      end
      default: bad_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea      <= sum_d;
        illegal <= bad_d;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ea) && $stable(illegal));
  assert_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == F_DIRECT |=> !illegal && ea == $past(disp));
  assert_indirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == F_IND |=> !illegal && ea == $past(regs[base_sel*DATA_W +: DATA_W]));
  assert_short_index_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == F_ISD && !disp_is_long |=> illegal);
  assert_sp_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mode == F_ISD || mode == F_BI || mode == F_BID)
      && index_sel == SEL_W'(SP_SEL) |=> illegal);
  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode[2:1] == 2'b11 |=> illegal);
  always @(posedge clk)
    if (!rst_n) assert_reset_R1: assert (!out_valid && !illegal && ea == '0);

endmodule

// File: tb/scaled_ea_unit_test.sv
module scaled_ea_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   mode = '0;
  logic [255:0] regs;
  logic [2:0]   base_sel = '0, index_sel = '0;
  logic [1:0]   scale_code = '0;
  logic [31:0]  disp = '0;
  logic         disp_is_long = 1'b0;
  logic         out_valid, illegal;
  logic [31:0]  ea;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  scaled_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .regs(regs),
    .base_sel(base_sel), .index_sel(index_sel), .scale_code(scale_code),
    .disp(disp), .disp_is_long(disp_is_long),
    .out_valid(out_valid), .ea(ea), .illegal(illegal)
  );

  function automatic logic [31:0] reg_val(int k);
    return 32'h9E37_79B9 * (k + 1) + 32'h0F00_0000;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    logic [31:0] dvals [3];
    dvals[0] = 32'h1234_5677;
    dvals[1] = 32'hABCD_EF85;
    dvals[2] = 32'hFFFF_FF10;
    for (int k = 0; k < 8; k++) regs[k*32 +: 32] = reg_val(k);

    repeat (3) @(negedge clk);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 ea", ea, 32'd0);
    check("R1 illegal", {31'b0, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 8; m++)
      for (int b = 0; b < 8; b++)
        for (int x = 0; x < 8; x++)
          for (int s = 0; s < 4; s++)
            for (int l = 0; l < 2; l++)
              for (int d = 0; d < 3; d++) begin
                logic [31:0] de, bv, iv, exp;
                logic        bad;
                string       tag;
                in_valid = 1'b1; mode = 3'(m); base_sel = 3'(b); index_sel = 3'(x);
                scale_code = 2'(s); disp_is_long = l[0]; disp = dvals[d];
                // R4 sign extension, R3 scale, R13 wrap computed here
                de  = l ? dvals[d] : {{24{dvals[d][7]}}, dvals[d][7:0]};
                bv  = reg_val(b);
                iv  = reg_val(x) * (32'd1 << s);
                bad = 1'b0; exp = 32'd0;
                case (m)
                  0: begin exp = dvals[d];     tag = "R5"; end
                  1: begin exp = bv;           tag = "R6"; end
                  2: begin exp = bv + de;      tag = "R7 R4 R13"; end
                  3: begin exp = iv + de;      tag = "R8 R3 R4 R13"; bad = (x == 4) || !l; end
                  4: begin exp = bv + iv;      tag = "R9 R3 R13";    bad = (x == 4); end
                  5: begin exp = bv + iv + de; tag = "R10 R3 R4 R13"; bad = (x == 4); end
                  default: begin tag = "R12"; bad = 1'b1; end
                endcase
                @(negedge clk);
                check("R2 out_valid", {31'b0, out_valid}, 32'd1);
                if (bad) check({tag, " R11 illegal"}, {31'b0, illegal}, 32'd1);
                else begin
                  check({tag, " illegal"}, {31'b0, illegal}, 32'd0);
                  check({tag, " ea"}, ea, exp);
                end
              end

    // R14 / R2: idle cycles must not move outputs
    begin
      logic [31:0] held_ea;
      logic        held_ill;
      in_valid = 1'b1; mode = 3'd2; base_sel = 3'd1; disp_is_long = 1'b1; disp = 32'h40;
      @(negedge clk);
      held_ea = ea; held_ill = illegal;
      check("R7 ea before idle", held_ea, reg_val(1) + 32'h40);
      in_valid = 1'b0;
      for (int i = 0; i < 8; i++) begin
        mode = 3'(i); base_sel = 3'(7 - i); index_sel = 3'd4; disp = 32'hDEAD_0000 + i;
        disp_is_long = i[0];
        @(negedge clk);
        check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R14 ea held", ea, held_ea);
        check("R14 illegal held", {31'b0, illegal}, {31'b0, held_ill});
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule